// File: doc/BRIEF.md
# CAN Controller Status and Interrupt Register Block

This block holds the status and interrupt registers of a CAN controller. The status word shows which operating mode is active. It also shows whether the transmit FIFO or the high-priority transmit buffer is full, and whether the acceptance filter registers are being settled. The protocol engine supplies the mode select and the fullness levels as plain inputs, and the block registers them into the status word.

The interrupt side gathers a vector of event pulses into a sticky status register. Each status bit is gated by an enable register, and the gated bits are ORed into one registered interrupt line. Software clears status bits through a write-only clear register.

The block also owns the acceptance filter enable register and one mask register and one ID register per filter. When software writes 0 to a valid enable bit, a guard window opens for a fixed number of clocks. During that window, writes to the mask and ID registers are dropped. Access is a plain single-cycle write strobe with a combinational read port. The register port carries no stream of data, so it has no valid/ready handshake and never applies back-pressure.

Top module: `can_stat_irq_regs`

## Requirements
- R1: After reset the status word (address 0) reads 0x8000_0000. The interrupt status (address 1) and interrupt enable (address 2) read 0, and `irq` is 0.
- R2: Exactly one mode bit of the status word is 1, one clock after `mode_sel` is applied. The encoding is: 0 gives bit 31 (configuration), 1 gives bit 28 (normal), 2 gives bit 29 (sleep) and 3 gives bit 30 (loopback).
- R3: Status bit 21 follows `txfifo_full` and bit 22 follows `hpbuf_full`, each one clock later. Bits 0–19 and 23–27 always read 0.
- R4: A write to the status address, or to the interrupt status address, changes nothing.
- R5: A write to the filter enable register (address 4) that has 0 in any of its low NUM_FILTERS bits sets status bit 20 for SETTLE (4) clocks. The enable register reads back its low NUM_FILTERS bits.
- R6: Filter i has its mask register at address 8+2i and its ID register at address 9+2i. A write to either one is stored only while status bit 20 is 0; otherwise it is dropped.
- R7: With NUM_FILTERS = 0, status bit 20 always reads 0.
- R8: An `evt` pulse sets the matching interrupt status bit, and the bit stays set until it is cleared.
- R9: Writing 1s to the interrupt clear register (address 3) clears the matching interrupt status bits. Bits written as 0 are left as they are.
- R10: If an event and a clear hit the same bit in the same cycle, the bit stays 1.
- R11: The interrupt clear address always reads 0.
- R12: `irq` is the registered OR of the interrupt status bits ANDed with their enable bits, so it changes one clock after either register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| mode_sel | input | 2 | Operating mode select (0 cfg, 1 normal, 2 sleep, 3 loopback) |
| txfifo_full | input | 1 | Transmit FIFO full level |
| hpbuf_full | input | 1 | High-priority transmit buffer full level |
| evt | input | NUM_EVENTS | Interrupt event pulses |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds two copies of the block side by side with the same stimulus. The first uses four filters, eight events and a settle time of 4. This brings the guard window, the per-filter address decode and the blocked mask and ID writes within reach. The second uses zero filters, so the generate branch that ties the busy flag to 0 is exercised against the same event and mode traffic. A behavioural model in the bench predicts every register read and the `irq` level on each clock for both copies.

// File: rtl/can_sir_pkg.sv
package can_sir_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'd0;
  localparam logic [ADDR_W-1:0] A_ISR    = 5'd1;
  localparam logic [ADDR_W-1:0] A_IER    = 5'd2;
  localparam logic [ADDR_W-1:0] A_ICR    = 5'd3;
  localparam logic [ADDR_W-1:0] A_FEN    = 5'd4;
  localparam int FILT_BASE = 8;

  typedef enum logic [1:0] {
    OPM_CFG   = 2'd0,
    OPM_NORM  = 2'd1,
    OPM_SLEEP = 2'd2,
    OPM_LPBK  = 2'd3
  } opmode_t;

  // one-hot mode vector order: [3]=cfg [2]=loopback [1]=sleep [0]=normal
  localparam logic [3:0] OH_CFG = 4'b1000;
endpackage

// File: rtl/csr_mode_status.sv
module csr_mode_status
  import can_sir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       txf_in,
  input  logic       hpf_in,
  output logic [3:0] mode_oh,
  output logic       txf_q,
  output logic       hpf_q
);
  opmode_t sel;
  assign sel = opmode_t'(mode_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_oh <= OH_CFG;
      txf_q   <= 1'b0;
      hpf_q   <= 1'b0;
    end else begin
      txf_q <= txf_in;
      hpf_q <= hpf_in;
      unique case (sel)
        OPM_CFG:   mode_oh <= 4'b1000;
        OPM_NORM:  mode_oh <= 4'b0001;
        OPM_SLEEP: mode_oh <= 4'b0010;
        OPM_LPBK:  mode_oh <= 4'b0100;
        default:   mode_oh <= OH_CFG;
      endcase
    end
  end

  // R2
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);
endmodule

// File: rtl/csr_filter_guard.sv
module csr_filter_guard
  import can_sir_pkg::*;
#(
  parameter int NF     = 4,
  parameter int SETTLE = 4,
  parameter int AW     = 5,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(SETTLE + 1);

  generate
    if (NF == 0) begin : g_none
      assign busy    = 1'b0;
      assign rd_hit  = 1'b0;
      assign rd_data = '0;
    end else begin : g_filt
      logic [NF-1:0] fen_q;
      logic [CW-1:0] cnt_q;
      logic [DW-1:0] mask_q [NF];
      logic [DW-1:0] id_q   [NF];
      logic          fen_we;

      assign fen_we = wr_en && (addr == A_FEN);
      assign busy   = (cnt_q != '0);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          fen_q <= '0;
          cnt_q <= '0;
        end else begin
          if (fen_we) fen_q <= wdata[NF-1:0];
          if (fen_we && !(&wdata[NF-1:0])) cnt_q <= CW'(SETTLE);
          else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
        end
      end

      for (genvar i = 0; i < NF; i++) begin : g_reg
        logic m_we, i_we;
        assign m_we = wr_en && !busy && (addr == AW'(FILT_BASE + 2*i));
        assign i_we = wr_en && !busy && (addr == AW'(FILT_BASE + 2*i + 1));
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            mask_q[i] <= '0;
            id_q[i]   <= '0;
          end else begin
            if (m_we) mask_q[i] <= wdata;
            if (i_we) id_q[i]   <= wdata;
          end
        end
        // R6
        blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (busy && wr_en && addr == AW'(FILT_BASE + 2*i)) |=> $stable(mask_q[i]));
      end

      always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        if (addr == A_FEN) begin
          rd_hit  = 1'b1;
          rd_data = DW'(fen_q);
        end
        for (int k = 0; k < NF; k++) begin
          if (addr == AW'(FILT_BASE + 2*k)) begin
            rd_hit  = 1'b1;
            rd_data = mask_q[k];
          end
          if (addr == AW'(FILT_BASE + 2*k + 1)) begin
            rd_hit  = 1'b1;
            rd_data = id_q[k];
          end
        end
      end

      // R5
      busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(fen_we));
      // R5
      settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SETTLE));
    end
  endgenerate
endmodule

// File: rtl/csr_irq_ctrl.sv
module csr_irq_ctrl #(
  parameter int NE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt,
  input  logic          ier_we,
  input  logic          icr_we,
  input  logic [NE-1:0] wdata,
  output logic [NE-1:0] isr_q,
  output logic [NE-1:0] ier_q,
  output logic          irq_o
);
  logic [NE-1:0] clr_bits;
  assign clr_bits = icr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      ier_q <= '0;
      irq_o <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~clr_bits) | evt;
      if (ier_we) ier_q <= wdata;
      irq_o <= |(isr_q & ier_q);
    end
  end

  // R8 R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((isr_q & $past(evt)) == $past(evt)));
  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_we && evt == '0) |=> ((isr_q & $past(clr_bits)) == '0));
  // R12
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q == '0 || ier_q == '0) |=> !irq_o);
endmodule

// File: rtl/can_stat_irq_regs.sv
module can_stat_irq_regs
  import can_sir_pkg::*;
#(
  parameter int NUM_FILTERS = 4,
  parameter int NUM_EVENTS  = 8,
  parameter int SETTLE      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [1:0]            mode_sel,
  input  logic                  txfifo_full,
  input  logic                  hpbuf_full,
  input  logic [NUM_EVENTS-1:0] evt,
  output logic                  irq
);
  logic [3:0]            mode_oh;
  logic                  txf_q, hpf_q, busy;
  logic                  f_hit;
  logic [31:0]           f_data;
  logic [NUM_EVENTS-1:0] isr, ier;
  logic [31:0]           status_w;

  csr_mode_status u_mode (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .txf_in(txfifo_full), .hpf_in(hpbuf_full),
    .mode_oh(mode_oh), .txf_q(txf_q), .hpf_q(hpf_q)
  );

  csr_filter_guard #(.NF(NUM_FILTERS), .SETTLE(SETTLE), .AW(ADDR_W), .DW(32)) u_filt (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .rd_hit(f_hit), .rd_data(f_data)
  );

  csr_irq_ctrl #(.NE(NUM_EVENTS)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .ier_we(bus_wr && bus_addr == A_IER),
    .icr_we(bus_wr && bus_addr == A_ICR),
    .wdata(bus_wdata[NUM_EVENTS-1:0]),
    .isr_q(isr), .ier_q(ier), .irq_o(irq)
  );

  assign status_w = {mode_oh, 5'b0, hpf_q, txf_q, busy, 20'b0};

  always_comb begin
    unique case (bus_addr)
      A_STATUS: bus_rdata = status_w;
      A_ISR:    bus_rdata = 32'(isr);
      A_IER:    bus_rdata = 32'(ier);
      A_ICR:    bus_rdata = '0;
      default:  bus_rdata = f_hit ? f_data : '0;
    endcase
  end

  // R3
  status_gaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[19:0] == '0 && status_w[27:23] == '0);
  // R7
  no_filter_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_FILTERS == 0) |-> !status_w[20]);
endmodule

// File: tb/sim_can_stat_irq_regs.sv
module sim_can_stat_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int NE = 8;
  localparam int ST = 4;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic [1:0] mode_sel = 2'd0;
  logic txf = 0, hpf = 0;
  logic [NE-1:0] evt = '0;
  logic irq0, irq1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stat_irq_regs #(.NUM_FILTERS(NF), .NUM_EVENTS(NE), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd0), .mode_sel(mode_sel), .txfifo_full(txf), .hpbuf_full(hpf),
    .evt(evt), .irq(irq0));
  can_stat_irq_regs #(.NUM_FILTERS(0), .NUM_EVENTS(NE), .SETTLE(ST)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd1), .mode_sel(mode_sel), .txfifo_full(txf), .hpbuf_full(hpf),
    .evt(evt), .irq(irq1));

  // behavioural reference
  int m_mode, m_cnt;
  bit m_txf, m_hpf, m_irq;
  int unsigned m_isr, m_ier, m_fen;
  int unsigned m_mask [NF];
  int unsigned m_id [NF];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_txf = 0; m_hpf = 0; m_irq = 0;
      m_isr = 0; m_ier = 0; m_fen = 0;
      for (int i = 0; i < NF; i++) begin m_mask[i] = 0; m_id[i] = 0; end
    end else begin
      int busy_now;
      busy_now = (m_cnt > 0);
      m_irq = ((m_isr & m_ier) != 0);
      m_mode = mode_sel; m_txf = txf; m_hpf = hpf;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (bus_wr) begin
        if (bus_addr == 3) m_isr = m_isr & ~(bus_wdata & 32'hFF);
        if (bus_addr == 2) m_ier = bus_wdata & 32'hFF;
        if (bus_addr == 4) begin
          m_fen = bus_wdata & 32'hF;
          if (m_fen != 32'hF) m_cnt = ST;
        end
        if (!busy_now && bus_addr >= 8 && bus_addr < 8 + 2*NF) begin
          if (bus_addr % 2 == 0) m_mask[(bus_addr-8)/2] = bus_wdata;
          else                   m_id[(bus_addr-8)/2]   = bus_wdata;
        end
      end
      m_isr = m_isr | evt;
    end
  end

  function automatic int unsigned exp_read(int a, bit with_filt);
    int unsigned s;
    case (a)
      0: begin
        s = 0;
        case (m_mode) 0: s[31] = 1; 1: s[28] = 1; 2: s[29] = 1; default: s[30] = 1; endcase
        s[21] = m_txf; s[22] = m_hpf; s[20] = with_filt && (m_cnt > 0);
        return s;
      end
      1: return m_isr;
      2: return m_ier;
      3: return 0;
      4: return with_filt ? m_fen : 0;
      default: begin
        if (with_filt && a >= 8 && a < 8 + 2*NF)
          return (a % 2 == 0) ? m_mask[(a-8)/2] : m_id[(a-8)/2];
        return 0;
      end
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // R12: irq compared with the model every clock
  always @(negedge clk) if (rst_n && !done) begin
    chk(irq0 == m_irq, "R12 irq u0", irq0, m_irq);
    chk(irq1 == m_irq, "R12 irq u1", irq1, m_irq);
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(int a, int unsigned d);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = d; tick(); bus_wr = 0;
  endtask

  task automatic rd(int a, string tag);
    int unsigned e0, e1;
    bus_addr = 5'(a); #1;
    e0 = exp_read(a, 1); e1 = exp_read(a, 0);
    chk(rd0 == e0, tag, rd0, e0);
    chk(rd1 == e1, {tag, " u1"}, rd1, e1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, "R1 status"); chk(rd0 == 32'h8000_0000, "R1 status const", rd0, 32'h8000_0000);
    rd(1, "R1 isr"); rd(2, "R1 ier");
    chk(irq0 == 0, "R1 irq", irq0, 0);
    // R2 modes
    for (int m = 3; m >= 0; m--) begin
      mode_sel = 2'(m); tick(); rd(0, "R2 mode");
    end
    // R3 fullness
    txf = 1; tick(); rd(0, "R3 txf");
    hpf = 1; txf = 0; tick(); rd(0, "R3 hpf");
    txf = 1; tick(); rd(0, "R3 both");
    // R4 writes to read-only registers
    wr(0, 32'hFFFF_FFFF); rd(0, "R4 status ro");
    wr(1, 32'hFF); rd(1, "R4 isr ro");
    // R6 filter regs writable when idle; all-ones enable keeps busy low
    wr(4, 32'hF); rd(0, "R5 no busy"); rd(4, "R5 fen");
    for (int i = 0; i < NF; i++) begin
      wr(8 + 2*i, 32'hA000_0000 + i); wr(9 + 2*i, 32'h0B00_0000 + i);
    end
    for (int i = 0; i < 2*NF; i++) rd(8 + i, "R6 stored");
    // R5 busy window, R7 on u1
    wr(4, 32'h7); rd(0, "R5 busy set"); rd(4, "R5 fen 7");
    chk(rd1[20] == 0, "R7 u1 busy", rd1[20], 0);
    wr(8, 32'hDEAD_0001); rd(8, "R6 blocked");
    wr(11, 32'hDEAD_0002); rd(11, "R6 blocked id");
    tick(); rd(0, "R5 busy late");
    tick(); rd(0, "R5 busy end"); chk(rd0[20] == 0, "R5 cleared", rd0[20], 0);
    wr(8, 32'h1234_5678); rd(8, "R6 after window");
    // R8 events
    evt = 8'h05; tick(); evt = 0; rd(1, "R8 set");
    tick(); rd(1, "R8 held");
    // R12 enable
    wr(2, 32'h04); rd(2, "R12 ier"); tick(); tick();
    chk(irq0 == 1, "R12 irq on", irq0, 1);
    // R9 clear
    wr(3, 32'h04); rd(1, "R9 partial clear");
    tick(); chk(irq0 == 0, "R12 irq off", irq0, 0);
    // R10 same-cycle set and clear
    evt = 8'h01; wr(3, 32'h01); evt = 0; rd(1, "R10 set wins");
    chk(rd0[0] == 1, "R10 bit0", rd0[0], 1);
    evt = 8'hF0; wr(3, 32'h0F); evt = 0; rd(1, "R9 R10 mixed");
    // R11
    rd(3, "R11 icr");
    wr(2, 32'hFF); tick(); tick();
    wr(3, 32'hFF); tick(); tick(); rd(1, "R9 all clear");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule